// File: doc/BRIEF.md
# Flash ECC Policy and Single-Error Budget Controller

This block sets the error-checking policy for a flash array whose words are 256 bits wide. Each word carries a 3-bit control tag. A write either leaves the tag erased, which marks the word as parity-protected, or programs it, which marks the word as ECC-protected. On every read, the block decides whether the corrected data path should be used. It also decides whether a reported double error or parity error becomes a bus error, and whether a single-bit correction uses up part of an error budget.

Software reaches the block through one 16-bit configuration word:

| Bits | Field |
|------|-------|
| [15:8] | Single-error budget |
| [6] | Unlock bit |
| [5:4] | Two-bit mode |
| [0] | Write-1-to-clear for the sticky single-error flag (write); current flag value (read) |

All other bits read as zero.

Clearing the unlock bit freezes both the unlock bit and the mode until the next reset. The budget loads a saturating down-counter. A single-error event that arrives once the counter has reached zero raises the sticky flag.

Top module: `flash_ecc_policy`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x0070 (budget 0, unlock 1, mode 11, flag 0), `err_left` is 0 and `bus_err` is 0.
- R2: `wr_ctl` is 3'b000 when `wr_quad`=1 and 3'b111 when `wr_quad`=0. `wr_reject` is 1 only for a single write (`wr_valid`=1, `wr_quad`=0) while mode is 00.
- R3: While the unlock bit is 0, a configuration write leaves the unlock bit and the mode unchanged but still loads the budget. While the unlock bit is 1, a write sets all three fields.
- R4: `rd_use_ecc` follows the mode:
  - mode 00: always 1.
  - mode 11: always 0.
  - modes 01 and 10: 1 when the majority of the `rd_ctl` bits are 0, else 0.
- R5: `bus_err` is a registered one-cycle pulse, high in the cycle after a read that has `rd_ded` or `rd_par` set. This happens only in modes 00 and 01, never in 10 or 11.
- R6: A configuration write loads `err_left` with bits [15:8]. Each single-error event decrements it by one, and it holds at 0 instead of wrapping.
- R7: A single-error event while `err_left` is 0 sets `serr_flag`. The flag stays set through budget reloads and is cleared only by a configuration write with bit 0 = 1. A set in the same cycle wins over a clear.
- R8: A single-error event is a checked read with `rd_sec`=1. In mode 01, a read whose `rd_ctl` is neither 3'b000 nor 3'b111 is also an event. A read counts as at most one event.
- R9: `dbg_override` suppresses bus errors and single-error events only while the unlock bit is 1. While the unlock bit is 0, it has no effect.
- R10: In mode 11, reads raise no bus error and produce no single-error event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration readback |
| wr_valid | input | 1 | Flash write request |
| wr_quad | input | 1 | 1 = quad-word write, 0 = single-word write |
| wr_ctl | output | 3 | Control tag to program with the write |
| wr_reject | output | 1 | Single write refused in mode 00 |
| rd_valid | input | 1 | Read status valid |
| rd_sec | input | 1 | Decoder corrected a single-bit error |
| rd_ded | input | 1 | Decoder detected a double error |
| rd_par | input | 1 | Parity check failed |
| rd_ctl | input | 3 | Stored control tag of the word read |
| dbg_override | input | 1 | Debug request to mask checking and reporting |
| rd_use_ecc | output | 1 | Select corrected data path |
| bus_err | output | 1 | One-cycle bus error pulse |
| serr_flag | output | 1 | Sticky single-error-budget-exhausted flag |
| err_left | output | 8 | Remaining single-error budget |

## Verification
The bench sweeps mixed control tags through every mode. A design that voted wrongly, or that ignored the per-word tag in mode 10, would select the wrong data path.

It also tests the following corner cases:
- It drains the budget to zero and then fires one more event. A design that wrapped, or that flagged one event early, would show the wrong count or raise the flag too soon.
- It reloads the budget while the flag is set. A design that tied clear to reload would drop the flag.
- It locks the block and then issues a debug override and a configuration write. A design that still honoured the override or changed the mode would mask the bus error or alter the readback.

// File: rtl/flash_ecc_policy.sv
module flash_ecc_policy #(
  parameter int BW = 8,
  parameter int CW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [BW+7:0]    cfg_wdata,
  output logic [BW+7:0]    cfg_rdata,
  input  logic             wr_valid,
  input  logic             wr_quad,
  output logic [CW-1:0]    wr_ctl,
  output logic             wr_reject,
  input  logic             rd_valid,
  input  logic             rd_sec,
  input  logic             rd_ded,
  input  logic             rd_par,
  input  logic [CW-1:0]    rd_ctl,
  input  logic             dbg_override,
  output logic             rd_use_ecc,
  output logic             bus_err,
  output logic             serr_flag,
  output logic [BW-1:0]    err_left
);
  localparam logic [1:0] M_ECC = 2'b00, M_DYN = 2'b01, M_BYP = 2'b11;

  logic [1:0]    mode_q;
  logic          unlock_q;
  logic [BW-1:0] bud_q;
  logic          maj_one, ctl_bad, dbg_eff, sec_evt, clr;

  always_comb begin
    int n;
    n = 0;
    for (int i = 0; i < CW; i++) n += int'(rd_ctl[i]);
    maj_one = (n > CW / 2);
  end

  assign ctl_bad    = (rd_ctl != '0) && (rd_ctl != '1);
  assign dbg_eff    = dbg_override & unlock_q;
  assign sec_evt    = rd_valid & (mode_q != M_BYP) & ~dbg_eff &
                      (rd_sec | ((mode_q == M_DYN) & ctl_bad));
  assign clr        = cfg_we & cfg_wdata[0];

  assign wr_ctl     = wr_quad ? '0 : '1;
  assign wr_reject  = wr_valid & ~wr_quad & (mode_q == M_ECC);
  assign rd_use_ecc = (mode_q == M_ECC) ? 1'b1 :
                      (mode_q == M_BYP) ? 1'b0 : ~maj_one;
  assign cfg_rdata  = {bud_q, 1'b0, unlock_q, mode_q, 3'b000, serr_flag};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= M_BYP;
      unlock_q  <= 1'b1;
      bud_q     <= '0;
      err_left  <= '0;
      serr_flag <= 1'b0;
      bus_err   <= 1'b0;
    end else begin
      bus_err   <= rd_valid & ~mode_q[1] & ~dbg_eff & (rd_ded | rd_par);
      serr_flag <= (serr_flag & ~clr) | (sec_evt & (err_left == '0));
      if (cfg_we) begin
        bud_q    <= cfg_wdata[BW+7:8];
        err_left <= cfg_wdata[BW+7:8];
        if (unlock_q) begin
          unlock_q <= cfg_wdata[6];
          mode_q   <= cfg_wdata[5:4];
        end
      end else if (sec_evt && err_left != '0) begin
        err_left <= err_left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_ecc_policy_chk.sv
module flash_ecc_policy_chk #(
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [BW+7:0] cfg_wdata,
  input logic          rd_valid,
  input logic          rd_ded,
  input logic          bus_err,
  input logic          serr_flag,
  input logic [BW-1:0] err_left,
  input logic          unlock_q,
  input logic [1:0]    mode_q
);
  a_r3_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(unlock_q) |-> (!unlock_q && mode_q == $past(mode_q)));

  a_r5_bus_err_source: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> ($past(rd_valid) && !$past(mode_q[1])));

  a_r6_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cfg_we) && err_left != $past(err_left)) |-> (err_left == BW'($past(err_left) - 1'b1)));

  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cfg_we) && $past(err_left) == '0) |-> (err_left == '0));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(serr_flag) && !($past(cfg_we) && $past(cfg_wdata[0]))) |-> serr_flag);

  a_r9_locked_debug: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_valid && rd_ded && !unlock_q && !mode_q[1]) |-> bus_err);
endmodule

bind flash_ecc_policy flash_ecc_policy_chk #(.BW(BW)) u_chk (.*);

// File: tb/flash_ecc_policy_tb.sv
module flash_ecc_policy_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, wr_valid = 0, wr_quad = 0, rd_valid = 0;
  logic rd_sec = 0, rd_ded = 0, rd_par = 0, dbg_override = 0;
  logic [15:0] cfg_wdata = '0, cfg_rdata;
  logic [2:0] rd_ctl = '0, wr_ctl;
  logic wr_reject, rd_use_ecc, bus_err, serr_flag;
  logic [7:0] err_left;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  flash_ecc_policy u_dut (.*);

  // {mode, ctl, expected rd_use_ecc}
  localparam logic [5:0] VEC [12] = '{
    {2'b00,3'b000,1'b1}, {2'b00,3'b111,1'b1}, {2'b01,3'b000,1'b1},
    {2'b01,3'b111,1'b0}, {2'b01,3'b001,1'b1}, {2'b01,3'b110,1'b0},
    {2'b10,3'b000,1'b1}, {2'b10,3'b111,1'b0}, {2'b10,3'b011,1'b0},
    {2'b10,3'b100,1'b1}, {2'b11,3'b000,1'b0}, {2'b11,3'b111,1'b0}};

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cfg(logic [15:0] d);
    cfg_we = 1; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0; cfg_wdata = '0;
  endtask

  task automatic rd(logic s, logic d, logic p, logic [2:0] c);
    rd_valid = 1; rd_sec = s; rd_ded = d; rd_par = p; rd_ctl = c;
    @(posedge clk); #1;
    rd_valid = 0; rd_sec = 0; rd_ded = 0; rd_par = 0;
  endtask

  task automatic idle();
    @(posedge clk); #1;
  endtask

  initial begin
    #20000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle();
    chk("R1 rdata", cfg_rdata, 16'h0070);
    chk("R1 err_left", 16'(err_left), 0);
    chk("R1 flag", 16'(serr_flag), 0);
    chk("R1 bus_err", 16'(bus_err), 0);

    wr_valid = 1; wr_quad = 0; #1;
    chk("R2 single ctl", 16'(wr_ctl), 16'h7);
    chk("R2 no reject mode11", 16'(wr_reject), 0);
    wr_quad = 1; #1;
    chk("R2 quad ctl", 16'(wr_ctl), 0);
    cfg(16'h0040);
    chk("R2 quad ok mode00", 16'(wr_reject), 0);
    wr_quad = 0; #1;
    chk("R2 single reject mode00", 16'(wr_reject), 1);
    wr_valid = 0;

    for (int i = 0; i < 12; i++) begin
      cfg({8'h00, 2'b01, VEC[i][5:4], 4'b0});
      rd_ctl = VEC[i][3:1]; #1;
      chk($sformatf("R4 vec%0d", i), 16'(rd_use_ecc), 16'(VEC[i][0]));
    end

    cfg(16'h0040);
    rd(0, 1, 0, 3'b000);
    chk("R5 mode00 ded pulse", 16'(bus_err), 1);
    idle();
    chk("R5 pulse ends", 16'(bus_err), 0);
    cfg(16'h0050);
    rd(0, 0, 1, 3'b111);
    chk("R5 mode01 par", 16'(bus_err), 1);
    cfg(16'h0060);
    rd(0, 1, 1, 3'b000);
    chk("R5 mode10 silent", 16'(bus_err), 0);
    cfg(16'h0070);
    rd(0, 1, 1, 3'b000);
    chk("R10 mode11 silent", 16'(bus_err), 0);

    cfg(16'h0350);
    chk("R6 load", 16'(err_left), 3);
    rd(1, 0, 0, 3'b000); chk("R6 dec1", 16'(err_left), 2);
    rd(1, 0, 0, 3'b000); chk("R6 dec2", 16'(err_left), 1);
    rd(1, 0, 0, 3'b000); chk("R6 dec3", 16'(err_left), 0);
    chk("R7 not yet", 16'(serr_flag), 0);
    rd(1, 0, 0, 3'b000);
    chk("R6 hold zero", 16'(err_left), 0);
    chk("R7 set at zero", 16'(serr_flag), 1);
    cfg(16'h0550);
    chk("R7 reload keeps flag", 16'(serr_flag), 1);
    chk("R6 reload", 16'(err_left), 5);
    cfg(16'h0551);
    chk("R7 w1c", 16'(serr_flag), 0);

    cfg(16'h0250);
    rd(0, 0, 0, 3'b001);
    chk("R8 ctl event mode01", 16'(err_left), 1);
    rd(1, 0, 0, 3'b110);
    chk("R8 single event per read", 16'(err_left), 0);
    cfg(16'h0260);
    rd(0, 0, 0, 3'b001);
    chk("R8 no ctl event mode10", 16'(err_left), 2);
    cfg(16'h0170);
    rd(1, 0, 0, 3'b000);
    chk("R10 mode11 no count", 16'(err_left), 1);

    cfg(16'h0140);
    dbg_override = 1;
    rd(1, 1, 0, 3'b000);
    chk("R9 unlocked override bus", 16'(bus_err), 0);
    chk("R9 unlocked override count", 16'(err_left), 1);
    cfg(16'h0100);
    chk("R3 lock taken", cfg_rdata, 16'h0100);
    rd(1, 1, 0, 3'b000);
    chk("R9 locked override bus", 16'(bus_err), 1);
    chk("R9 locked override count", 16'(err_left), 0);
    dbg_override = 0;
    cfg(16'h0270);
    chk("R3 locked write", cfg_rdata, 16'h0200);
    chk("R3 budget still loads", 16'(err_left), 2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule